// File: doc/BRIEF.md
# Split 64-bit Data Access Sequencer

This block lets a debug register port that is only 32 bits wide move one 64-bit word over a system bus. Software reaches the wide word by touching a single data register twice. A read pair starts one 64-bit bus read and hands the word back in two halves. A write pair collects both halves first and then issues one 64-bit bus write.

When wide mode is off, each data-register access maps to exactly one bus access. The sequencer also watches writes to the other port registers. Any of those writes abandons a sequence that is half done. A register access in the opposite direction to the open sequence is refused in the same way. An abandoned write pair never reaches the bus.

The bus side is a plain request/grant handshake followed by a single response beat. Address generation and the bus protocol engine sit outside this block.

Top module: `split_access_seq`

## Requirements
- R1: After synchronous reset, `reg_done`, `bus_req` and `busy` are low and no sequence is open.
- R2: With `wide_mode` high, a data-register read in the idle state raises `bus_req` with `bus_we` low in the next cycle. When the response arrives, `reg_done` pulses in the following cycle and `reg_rdata` carries response bits [31:0].
- R3: The next data-register read after R2 returns response bits [63:32] with `reg_done` in the cycle after the access, and it starts no bus access.
- R4: With `wide_mode` high, the first data-register write is acknowledged in the next cycle with no bus activity. The second write raises one bus write whose data is {second, first} and whose `bus_strb` is all ones. `reg_done` follows the response.
- R5: With `wide_mode` low, every data-register access makes exactly one bus access. A write places the data in bits [31:0], with the upper bits zero and `bus_strb` equal to 0x0F. A read returns bits [31:0] and holds nothing back.
- R6: A write to any offset other than the data offset (default 0x0C) while a read pair is half done discards the held upper half. The next data read starts a new bus read.
- R7: A write to any other offset while a write pair is half done discards the lower half, and no bus write results from it. The next data write is taken as a new lower half.
- R8: A data access in the opposite direction to a half-done pair is not recognised. It is answered in the next cycle with `reg_done` and `reg_err` high and `reg_rdata` zero, the pair is closed, and no bus access starts.
- R9: A read of any other offset is not acknowledged and leaves a half-done pair intact.
- R10: `busy` is high from the first cycle of `bus_req` until the cycle the response is taken, and low the cycle after.
- R11: An error response finishes the access with `reg_err` high and, for reads, `reg_rdata` zero. No upper half is held, so the next data read starts a new bus read.
- R12: `bus_req` stays high until `bus_gnt` is sampled, with `bus_we`, `bus_wdata` and `bus_strb` unchanged while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | One-cycle register access strobe |
| reg_write | input | 1 | Access is a write when high |
| reg_off | input | OFF_W | Register offset of the access |
| reg_wdata | input | HALF_W | Register write data |
| wide_mode | input | 1 | Data accesses use 64-bit pairs when high |
| reg_done | output | 1 | Data-register access finished (one-cycle pulse) |
| reg_err | output | 1 | Finished access was refused or got an error response |
| reg_rdata | output | HALF_W | Read data, valid with `reg_done` |
| bus_req | output | 1 | Bus request, held until granted |
| bus_we | output | 1 | Request is a write |
| bus_wdata | output | 2*HALF_W | Bus write data |
| bus_strb | output | HALF_W/4 | Byte strobes for the bus write |
| bus_gnt | input | 1 | Request accepted |
| bus_rsp_valid | input | 1 | Response beat |
| bus_rsp_err | input | 1 | Response signals an error |
| bus_rdata | input | 2*HALF_W | Response read data |
| busy | output | 1 | Bus transfer in progress |

## Verification
Every result is registered once. `bus_req` and `busy` rise in the cycle after the edge that samples the access. A held upper half, or the refusal of a mixed access, shows on `reg_done` in the cycle after the access. A bus-backed access completes one cycle after the edge that samples `bus_rsp_valid`, and `busy` drops at that same point.

The bench changes inputs only on falling edges and steps its own reference model on each rising edge. It compares every output at the next falling edge, so each result is sampled in exactly the cycle it is due. Explicit checks on the returned halves and on bus read and write counts then confirm that terminations and refusals left the bus untouched.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_WAIT    = 3'd2,
    ST_HOLD_RD = 3'd3,
    ST_HOLD_WR = 3'd4
  } sds_state_e;
endpackage

// File: rtl/sds_ctrl.sv
module sds_ctrl
  import sds_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_data,
  input  logic       acc_wr,
  input  logic       acc_other_wr,
  input  logic       wide_mode,
  input  logic       bus_gnt,
  input  logic       rsp_valid,
  input  logic       rsp_err,
  output sds_state_e state_o,
  output logic       wide_o,
  output logic       op_wr_o,
  output logic       done_o,
  output logic       err_o,
  output logic       cap_low,
  output logic       launch_wr,
  output logic       launch_wide,
  output logic       take_rsp,
  output logic       give_hi,
  output logic       give_zero,
  output logic       clr_hold
);
  sds_state_e st_q, st_n;
  logic wide_q, wide_n, opwr_q, opwr_n;
  logic done_q, done_n, err_q, err_n;

  always_comb begin
    st_n        = st_q;
    wide_n      = wide_q;
    opwr_n      = opwr_q;
    done_n      = 1'b0;
    err_n       = 1'b0;
    cap_low     = 1'b0;
    launch_wr   = 1'b0;
    launch_wide = 1'b0;
    take_rsp    = 1'b0;
    give_hi     = 1'b0;
    give_zero   = 1'b0;
    clr_hold    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (acc_data) begin
          if (acc_wr && wide_mode) begin
            cap_low = 1'b1;
            done_n  = 1'b1;
            wide_n  = 1'b1;
            st_n    = ST_HOLD_WR;
          end else if (acc_wr) begin
            launch_wr = 1'b1;
            opwr_n    = 1'b1;
            wide_n    = 1'b0;
            st_n      = ST_REQ;
          end else begin
            opwr_n = 1'b0;
            wide_n = wide_mode;
            st_n   = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (bus_gnt) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_valid) begin
          done_n   = 1'b1;
          err_n    = rsp_err;
          take_rsp = !opwr_q;
          st_n     = (!rsp_err && !opwr_q && wide_q) ? ST_HOLD_RD : ST_IDLE;
        end
      end
      ST_HOLD_RD: begin
        if (acc_data && !acc_wr) begin
          give_hi = 1'b1;
          done_n  = 1'b1;
          st_n    = ST_IDLE;
        end else if (acc_data) begin
          give_zero = 1'b1;
          done_n    = 1'b1;
          err_n     = 1'b1;
          clr_hold  = 1'b1;
          st_n      = ST_IDLE;
        end else if (acc_other_wr) begin
          clr_hold = 1'b1;
          st_n     = ST_IDLE;
        end
      end
      ST_HOLD_WR: begin
        if (acc_data && acc_wr) begin
          launch_wr   = 1'b1;
          launch_wide = 1'b1;
          opwr_n      = 1'b1;
          st_n        = ST_REQ;
        end else if (acc_data) begin
          give_zero = 1'b1;
          done_n    = 1'b1;
          err_n     = 1'b1;
          clr_hold  = 1'b1;
          st_n      = ST_IDLE;
        end else if (acc_other_wr) begin
          clr_hold = 1'b1;
          st_n     = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      wide_q <= 1'b0;
      opwr_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      wide_q <= wide_n;
      opwr_q <= opwr_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign state_o = st_q;
  assign wide_o  = wide_q;
  assign op_wr_o = opwr_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R3
  hi_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD_RD && acc_data && !acc_wr) |=> (done_q && !err_q && st_q == ST_IDLE));

  // R8
  mix_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (((st_q == ST_HOLD_RD) && acc_data && acc_wr) || ((st_q == ST_HOLD_WR) && acc_data && !acc_wr))
    |=> (done_q && err_q && st_q == ST_IDLE));

  // R7
  abandon_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HOLD_WR && acc_other_wr) |=> (st_q == ST_IDLE && !done_q));
endmodule

// File: rtl/sds_data.sv
module sds_data #(
  parameter int HALF_W = 32,
  localparam int BUS_W = 2 * HALF_W,
  localparam int STRB_W = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HALF_W-1:0] wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  input  logic              rsp_err,
  input  logic              cap_low,
  input  logic              launch_wr,
  input  logic              launch_wide,
  input  logic              take_rsp,
  input  logic              give_hi,
  input  logic              give_zero,
  input  logic              clr_hold,
  output logic [HALF_W-1:0] rdata_o,
  output logic [BUS_W-1:0]  bus_wdata_o,
  output logic [STRB_W-1:0] bus_strb_o
);
  localparam logic [STRB_W-1:0] STRB_LOW  = {{(STRB_W/2){1'b0}}, {(STRB_W/2){1'b1}}};
  localparam logic [STRB_W-1:0] STRB_FULL = {STRB_W{1'b1}};

  logic [HALF_W-1:0] low_q, hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q <= '0;
    end else if (cap_low) begin
      low_q <= wdata;
    end else if (clr_hold || launch_wr) begin
      low_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
    end else if (take_rsp) begin
      hi_q <= rsp_err ? '0 : bus_rdata[BUS_W-1:HALF_W];
    end else if (give_hi || clr_hold) begin
      hi_q <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (take_rsp) begin
      rdata_o <= rsp_err ? '0 : bus_rdata[HALF_W-1:0];
    end else if (give_hi) begin
      rdata_o <= hi_q;
    end else if (give_zero) begin
      rdata_o <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_wdata_o <= '0;
      bus_strb_o  <= '0;
    end else if (launch_wr) begin
      bus_wdata_o <= launch_wide ? {wdata, low_q} : {{HALF_W{1'b0}}, wdata};
      bus_strb_o  <= launch_wide ? STRB_FULL : STRB_LOW;
    end
  end
endmodule

// File: rtl/split_access_seq.sv
module split_access_seq
  import sds_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int OFF_W = 8,
  parameter logic [OFF_W-1:0] DATA_OFF = 8'h0C,
  localparam int BUS_W = 2 * HALF_W,
  localparam int STRB_W = BUS_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [HALF_W-1:0] reg_wdata,
  input  logic              wide_mode,
  output logic              reg_done,
  output logic              reg_err,
  output logic [HALF_W-1:0] reg_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_W-1:0]  bus_wdata,
  output logic [STRB_W-1:0] bus_strb,
  input  logic              bus_gnt,
  input  logic              bus_rsp_valid,
  input  logic              bus_rsp_err,
  input  logic [BUS_W-1:0]  bus_rdata,
  output logic              busy
);
  logic acc_data, acc_other_wr;
  sds_state_e st;
  logic wide_q, op_wr;
  logic cap_low, launch_wr, launch_wide, take_rsp, give_hi, give_zero, clr_hold;

  assign acc_data     = reg_valid && (reg_off == DATA_OFF);
  assign acc_other_wr = reg_valid && reg_write && (reg_off != DATA_OFF);

  sds_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .acc_data(acc_data), .acc_wr(reg_write), .acc_other_wr(acc_other_wr),
    .wide_mode(wide_mode), .bus_gnt(bus_gnt),
    .rsp_valid(bus_rsp_valid), .rsp_err(bus_rsp_err),
    .state_o(st), .wide_o(wide_q), .op_wr_o(op_wr),
    .done_o(reg_done), .err_o(reg_err),
    .cap_low(cap_low), .launch_wr(launch_wr), .launch_wide(launch_wide),
    .take_rsp(take_rsp), .give_hi(give_hi), .give_zero(give_zero),
    .clr_hold(clr_hold)
  );

  sds_data #(.HALF_W(HALF_W)) u_data (
    .clk(clk), .rst(rst),
    .wdata(reg_wdata), .bus_rdata(bus_rdata), .rsp_err(bus_rsp_err),
    .cap_low(cap_low), .launch_wr(launch_wr), .launch_wide(launch_wide),
    .take_rsp(take_rsp), .give_hi(give_hi), .give_zero(give_zero),
    .clr_hold(clr_hold),
    .rdata_o(reg_rdata), .bus_wdata_o(bus_wdata), .bus_strb_o(bus_strb)
  );

  assign bus_req = (st == ST_REQ);
  assign bus_we  = op_wr;
  assign busy    = (st == ST_REQ) || (st == ST_WAIT);

  // R4
  full_strb_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we && wide_q) |-> (bus_strb == {STRB_W{1'b1}}));

  // R10
  busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !bus_req && bus_rsp_valid) |=> !busy);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_we) && $stable(bus_wdata) && $stable(bus_strb)));
endmodule

// File: tb/split_access_seq_bench.sv
module split_access_seq_bench;
  localparam logic [7:0] DOFF = 8'h0C;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_valid = 0, reg_write = 0, wide_mode = 1;
  logic [7:0] reg_off = 0;
  logic [31:0] reg_wdata = 0;
  logic reg_done, reg_err, bus_req, bus_we, busy;
  logic [31:0] reg_rdata;
  logic [63:0] bus_wdata;
  logic [7:0] bus_strb;
  logic bus_gnt = 0, bus_rsp_valid = 0, bus_rsp_err = 0;
  logic [63:0] bus_rdata = 0;

  always #10 clk = ~clk;

  split_access_seq u_split_access_seq (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .wide_mode(wide_mode),
    .reg_done(reg_done), .reg_err(reg_err), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_strb(bus_strb),
    .bus_gnt(bus_gnt), .bus_rsp_valid(bus_rsp_valid), .bus_rsp_err(bus_rsp_err),
    .bus_rdata(bus_rdata), .busy(busy)
  );

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // Bus slave
  logic [63:0] slave_data = 0;
  logic slave_err = 0;
  int stall = 0, lat = 1, lat_cnt = 0;
  int rd_count = 0, wr_count = 0;
  logic [63:0] last_wd = 0;
  logic [7:0] last_strb = 0;

  always @(negedge clk) begin
    bus_gnt = 0;
    bus_rsp_valid = 0;
    bus_rsp_err = 0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        bus_rsp_valid = 1;
        bus_rsp_err = slave_err;
        bus_rdata = slave_data;
      end
    end else if (!rst && bus_req) begin
      if (stall > 0) stall--;
      else begin
        bus_gnt = 1;
        lat_cnt = lat;
        if (bus_we) begin
          wr_count++;
          last_wd = bus_wdata;
          last_strb = bus_strb;
        end else rd_count++;
      end
    end
  end

  // Behavioural reference: phase 0 idle, 1 requesting, 2 awaiting reply, 3 upper half held, 4 lower half held
  int ph = 0;
  logic m_wide = 0, m_we = 0;
  logic [31:0] m_low = 0, m_hi = 0;
  logic [63:0] m_wd = 0;
  logic [7:0] m_st = 0;
  logic e_done = 0, e_err = 0, e_rcmp = 0, started = 0;
  logic [31:0] e_rd = 0;

  always @(posedge clk) begin
    logic dacc, oacc;
    dacc = reg_valid && reg_off == DOFF;
    oacc = reg_valid && reg_write && reg_off != DOFF;
    e_done = 0; e_err = 0; e_rcmp = 0;
    if (rst) ph = 0;
    else begin
      case (ph)
        0: if (dacc) begin
             if (reg_write && wide_mode) begin m_low = reg_wdata; e_done = 1; ph = 4; end
             else if (reg_write) begin
               m_we = 1; m_wide = 0; m_wd = {32'h0, reg_wdata}; m_st = 8'h0F; ph = 1;
             end else begin m_we = 0; m_wide = wide_mode; ph = 1; end
           end
        1: if (bus_gnt) ph = 2;
        2: if (bus_rsp_valid) begin
             e_done = 1; e_err = bus_rsp_err;
             if (!m_we) begin
               e_rcmp = 1;
               e_rd = bus_rsp_err ? 32'h0 : bus_rdata[31:0];
               m_hi = bus_rdata[63:32];
             end
             ph = (!bus_rsp_err && !m_we && m_wide) ? 3 : 0;
           end
        3: if (dacc && !reg_write) begin e_done = 1; e_rcmp = 1; e_rd = m_hi; ph = 0; end
           else if (dacc) begin e_done = 1; e_err = 1; e_rcmp = 1; e_rd = 0; ph = 0; end
           else if (oacc) ph = 0;
        4: if (dacc && reg_write) begin
             m_we = 1; m_wd = {reg_wdata, m_low}; m_st = 8'hFF; ph = 1;
           end else if (dacc) begin e_done = 1; e_err = 1; e_rcmp = 1; e_rd = 0; ph = 0; end
           else if (oacc) ph = 0;
        default: ph = 0;
      endcase
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      chk("R12", "bus_req", bus_req, ph == 1);
      chk("R10", "busy", busy, ph == 1 || ph == 2);
      chk("R2", "reg_done", reg_done, e_done);
      if (e_done) chk("R8", "reg_err", reg_err, e_err);
      if (e_rcmp) chk("R3", "reg_rdata", reg_rdata, e_rd);
      if (ph == 1) begin
        chk("R12", "bus_we", bus_we, m_we);
        if (m_we) begin
          chk("R4", "bus_wdata", bus_wdata, m_wd);
          chk("R5", "bus_strb", bus_strb, m_st);
        end
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL R12 watchdog got %0d cycles expected completion", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] got_rd;
  logic got_err;

  task automatic data_acc(input logic wr, input logic [31:0] wd);
    @(negedge clk);
    reg_valid = 1; reg_write = wr; reg_off = DOFF; reg_wdata = wd;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
    for (int i = 0; i < 60; i++) begin
      if (reg_done) break;
      @(negedge clk);
    end
    got_rd = reg_rdata;
    got_err = reg_err;
  endtask

  task automatic other_acc(input logic wr, input logic [7:0] off);
    @(negedge clk);
    reg_valid = 1; reg_write = wr; reg_off = off; reg_wdata = 32'hCAFE_0000;
    @(negedge clk);
    reg_valid = 0; reg_write = 0; reg_off = 0;
  endtask

  initial begin
    int rc, wc;
    repeat (3) @(negedge clk);
    chk("R1", "reset reg_done", reg_done, 0);
    chk("R1", "reset bus_req", bus_req, 0);
    chk("R1", "reset busy", busy, 0);
    rst = 0;
    @(negedge clk);

    // R2 / R3 wide read pair with a stalled grant
    wide_mode = 1; slave_data = 64'hA1B2C3D4_11223344; stall = 2; lat = 2;
    data_acc(0, 0);
    chk("R2", "low half", got_rd, 32'h11223344);
    chk("R2", "one bus read", rd_count, 1);
    slave_data = 64'h0;
    data_acc(0, 0);
    chk("R3", "upper half", got_rd, 32'hA1B2C3D4);
    chk("R3", "no new bus read", rd_count, 1);

    // R4 wide write pair
    lat = 1;
    data_acc(1, 32'h55667788);
    chk("R4", "no write after first half", wr_count, 0);
    data_acc(1, 32'h99AABBCC);
    chk("R4", "single bus write", wr_count, 1);
    chk("R4", "joined data", last_wd, 64'h99AABBCC_55667788);
    chk("R4", "full strobes", last_strb, 8'hFF);

    // R5 narrow mode
    wide_mode = 0;
    data_acc(1, 32'hDEADBEEF);
    chk("R5", "narrow write count", wr_count, 2);
    chk("R5", "narrow data", last_wd, 64'h00000000_DEADBEEF);
    chk("R5", "narrow strobes", last_strb, 8'h0F);
    slave_data = 64'hFFFF0000_12345678;
    data_acc(0, 0);
    chk("R5", "narrow read", got_rd, 32'h12345678);
    data_acc(0, 0);
    chk("R5", "second narrow read hits bus", rd_count, 3);

    // R6 termination of read pair by another write
    wide_mode = 1; slave_data = 64'h01010101_02020202;
    data_acc(0, 0);
    other_acc(1, 8'h00);
    slave_data = 64'h03030303_04040404;
    data_acc(0, 0);
    chk("R6", "new bus read after abandon", rd_count, 5);
    chk("R6", "fresh low half", got_rd, 32'h04040404);
    other_acc(1, 8'h04);

    // R7 termination of write pair
    wc = wr_count;
    data_acc(1, 32'h1111AAAA);
    other_acc(1, 8'h04);
    repeat (4) @(negedge clk);
    chk("R7", "no bus write after abandon", wr_count, wc);
    data_acc(1, 32'h2222BBBB);
    data_acc(1, 32'h3333CCCC);
    chk("R7", "restarted pair", last_wd, 64'h3333CCCC_2222BBBB);

    // R8 mixed directions
    rc = rd_count; wc = wr_count;
    data_acc(0, 0);
    data_acc(1, 32'h77777777);
    chk("R8", "write during read pair refused", got_err, 1);
    chk("R8", "refused rdata zero", got_rd, 0);
    data_acc(1, 32'h88888888);
    data_acc(0, 0);
    chk("R8", "read during write pair refused", got_err, 1);
    repeat (3) @(negedge clk);
    chk("R8", "no bus write from mixed pair", wr_count, wc);
    chk("R8", "only the opening read used bus", rd_count, rc + 1);

    // R9 reads of other registers leave a pair intact
    slave_data = 64'hBEEF0001_FACE0002;
    data_acc(0, 0);
    other_acc(0, 8'h08);
    @(negedge clk);
    chk("R9", "other read not acknowledged", reg_done, 0);
    data_acc(0, 0);
    chk("R9", "upper half survives", got_rd, 32'hBEEF0001);

    // R11 error response
    slave_err = 1; slave_data = 64'h12121212_34343434;
    data_acc(0, 0);
    chk("R11", "error flag", got_err, 1);
    chk("R11", "error rdata", got_rd, 0);
    slave_err = 0;
    rc = rd_count;
    data_acc(0, 0);
    chk("R11", "next read goes to bus", rd_count, rc + 1);
    chk("R11", "next read data", got_rd, 32'h34343434);
    other_acc(1, 8'h00);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule